// File: doc/BRIEF.md
# Auto-Increment Palette Loader

This block holds a 256-entry colour lookup table and the host-side register interface that fills it. A host on a 32-bit register bus first writes a starting palette index. It then streams colour components through a single data register: red first, then green, then blue. The block tracks which component is due next in a small phase state machine. After each complete triplet it advances the index by one, so a host can load the whole table, or any run of it, with one index write followed by a stream of data writes. In both registers the payload is the most significant byte of the bus word, and the lower bits are ignored.

A separate pixel-side port lets a display pipeline look up any entry at any time. The parameter `PIX_REG` makes this lookup combinational (0, the default) or adds one output register (1). On reset the table holds black in every entry except the last one, which is white. Reads of the register window always return zero and have no side effects.

The phase state machine has three states. `PH_RED` is entered at reset and on every index write. `PH_GREEN` follows a data write taken in `PH_RED`. `PH_BLUE` follows a data write taken in `PH_GREEN`. A data write taken in `PH_BLUE` returns the machine to `PH_RED` and increments the index; this transition is called *advance*. An index write taken in any state is called *reload*: it moves to `PH_RED` and replaces the index.

Top module: `palette_dac`

## Requirements
- R1: After reset every entry reads back as 0x000000 on the pixel port, except entry 255, which reads 0xFFFFFF. The phase is `PH_RED`, so the first data write stores red.
- R2: A full-word write to byte offset 0x0 loads the index from wdata[31:24] and returns the phase to `PH_RED` from any state.
- R3: Successive full-word writes to byte offset 0x4 store wdata[31:24] into the red, then the green, then the blue component of the current index, in that order.
- R4: The data write that stores blue increments the index by one, with entry 255 followed by entry 0, and returns the phase to `PH_RED`.
- R5: A write whose byte enable is anything other than 4'b1111 changes neither the table, the index nor the phase.
- R6: A write to byte offset 0x8 or 0xC, or to an address with addr[1:0] not equal to zero, changes neither the table, the index nor the phase.
- R7: A read returns rdata = 0 and changes neither the table, the index nor the phase.
- R8: With PIX_REG = 0, the pixel port shows a new component value in the clock cycle that follows the write's clock edge, and shows the old value before that edge.
- R9: Bits 23:0 of a write do not affect the value stored or loaded.
- R10: pix_rgb packs red in bits 23:16, green in bits 15:8 and blue in bits 7:0 of the entry selected by pix_idx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one write per cycle |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 4 | Byte address within the 16-byte window |
| wdata | input | 32 | Write data; the payload is bits 31:24 |
| be | input | 4 | Byte enables; only 4'b1111 is accepted |
| rdata | output | 32 | Read data, always zero |
| pix_idx | input | 8 | Pixel-side lookup index |
| pix_rgb | output | 24 | Looked-up colour {red, green, blue} |

## Verification
A register write takes effect at the clock edge where wr_en is sampled. The index and phase change at that edge, and with the default combinational lookup the stored component shows on pix_rgb in the cycle that follows. The bench therefore drives every bus operation on a falling edge and checks the table on the next falling edge. It steers pix_idx there and waits a short settle time before it samples. For R8 the bench also samples just before the capturing rising edge, to confirm that the old value is still present at that point. The bus-side assertions look exactly one cycle ahead of the accepting edge.

// File: rtl/dac_pkg.sv
package dac_pkg;

    // Component phase of the data register sequence.
    typedef enum logic [1:0] {
        PH_RED   = 2'd0,
        PH_GREEN = 2'd1,
        PH_BLUE  = 2'd2
    } dac_phase_e;

    // Number of colour components per entry.
    localparam int unsigned NUM_COMP = 3;

    // Word offsets inside the register window.
    localparam int unsigned WORD_INDEX = 0;
    localparam int unsigned WORD_DATA  = 1;

endpackage

// File: rtl/dac_bus_decode.sv
module dac_bus_decode #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned COMP_W = 8
) (
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [DATA_W/8-1:0]   be,
    output logic                  idx_load,
    output logic                  dat_wr,
    output logic [COMP_W-1:0]     payload,
    output logic [DATA_W-1:0]     rdata
);
    import dac_pkg::*;

    localparam int unsigned BE_W   = DATA_W / 8;
    localparam int unsigned LSB_W  = $clog2(BE_W);
    localparam int unsigned WORD_W = ADDR_W - LSB_W;

    logic              full_word;
    logic              aligned;
    logic [WORD_W-1:0] word;
    logic              unused_bits;

    assign full_word = (be == {BE_W{1'b1}});
    assign aligned   = (addr[LSB_W-1:0] == '0);
    assign word      = addr[ADDR_W-1:LSB_W];

    assign idx_load  = wr_en && full_word && aligned && (word == WORD_W'(WORD_INDEX));
    assign dat_wr    = wr_en && full_word && aligned && (word == WORD_W'(WORD_DATA));

    // The payload always travels in the most significant byte.
    assign payload   = wdata[DATA_W-1 -: COMP_W];

    // The register window has no readable state.
    assign rdata     = '0;

    assign unused_bits = ^{wdata[DATA_W-COMP_W-1:0], rd_en};

endmodule

// File: rtl/dac_phase_fsm.sv
module dac_phase_fsm #(
    parameter int unsigned IDX_W  = 8,
    parameter int unsigned COMP_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      idx_load,
    input  logic                      dat_wr,
    input  logic [COMP_W-1:0]         payload,
    output logic [IDX_W-1:0]          cur_idx,
    output dac_pkg::dac_phase_e       phase,
    output logic [dac_pkg::NUM_COMP-1:0] cmp_wr
);
    import dac_pkg::*;

    dac_phase_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    // State register process.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_RED;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // Output and transition process.
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        cmp_wr  = '0;
        if (idx_load) begin
            // reload: any state -> PH_RED with a fresh index
            state_d = PH_RED;
            idx_d   = payload[COMP_W-1 -: IDX_W];
        end else if (dat_wr) begin
            unique case (state_q)
                PH_RED: begin
                    cmp_wr[0] = 1'b1;
                    state_d   = PH_GREEN;
                end
                PH_GREEN: begin
                    cmp_wr[1] = 1'b1;
                    state_d   = PH_BLUE;
                end
                PH_BLUE: begin
                    // advance: triplet complete
                    cmp_wr[2] = 1'b1;
                    state_d   = PH_RED;
                    idx_d     = idx_q + 1'b1;
                end
                default: begin
                    state_d   = PH_RED;
                end
            endcase
        end
    end

    assign cur_idx = idx_q;
    assign phase   = state_q;

endmodule

// File: rtl/dac_palette_store.sv
module dac_palette_store #(
    parameter int unsigned ENTRIES = 256,
    parameter int unsigned COMP_W  = 8,
    parameter bit          PIX_REG = 1'b0
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [dac_pkg::NUM_COMP-1:0]       cmp_wr,
    input  logic [$clog2(ENTRIES)-1:0]         wr_idx,
    input  logic [COMP_W-1:0]                  wr_val,
    input  logic [$clog2(ENTRIES)-1:0]         pix_idx,
    output logic [dac_pkg::NUM_COMP*COMP_W-1:0] pix_rgb
);
    import dac_pkg::*;

    localparam int unsigned RGB_W = NUM_COMP * COMP_W;

    logic [RGB_W-1:0] lookup;

    // One storage array per colour component; component 0 (red) is the top field.
    for (genvar c = 0; c < NUM_COMP; c++) begin : g_comp
        logic [COMP_W-1:0] mem [ENTRIES];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < ENTRIES; i++) begin
                    mem[i] <= (i == ENTRIES - 1) ? {COMP_W{1'b1}} : '0;
                end
            end else if (cmp_wr[c]) begin
                mem[wr_idx] <= wr_val;
            end
        end

        assign lookup[RGB_W - c*COMP_W - 1 -: COMP_W] = mem[pix_idx];
    end

    if (PIX_REG) begin : g_pix_reg
        logic [RGB_W-1:0] rgb_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rgb_q <= '0;
            else        rgb_q <= lookup;
        end
        assign pix_rgb = rgb_q;
    end else begin : g_pix_comb
        assign pix_rgb = lookup;
    end

endmodule

// File: rtl/palette_dac.sv
module palette_dac #(
    parameter int unsigned ENTRIES = 256,
    parameter int unsigned COMP_W  = 8,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 4,
    parameter bit          PIX_REG = 1'b0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic                          rd_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [DATA_W-1:0]             wdata,
    input  logic [DATA_W/8-1:0]           be,
    output logic [DATA_W-1:0]             rdata,
    input  logic [$clog2(ENTRIES)-1:0]    pix_idx,
    output logic [3*COMP_W-1:0]           pix_rgb
);
    import dac_pkg::*;

    localparam int unsigned IDX_W = $clog2(ENTRIES);

    logic                idx_load;
    logic                dat_wr;
    logic [COMP_W-1:0]   payload;
    logic [IDX_W-1:0]    cur_idx;
    dac_phase_e          phase;
    logic [NUM_COMP-1:0] cmp_wr;

    dac_bus_decode #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .COMP_W (COMP_W)
    ) u_decode (
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wdata    (wdata),
        .be       (be),
        .idx_load (idx_load),
        .dat_wr   (dat_wr),
        .payload  (payload),
        .rdata    (rdata)
    );

    dac_phase_fsm #(
        .IDX_W  (IDX_W),
        .COMP_W (COMP_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_load (idx_load),
        .dat_wr   (dat_wr),
        .payload  (payload),
        .cur_idx  (cur_idx),
        .phase    (phase),
        .cmp_wr   (cmp_wr)
    );

    dac_palette_store #(
        .ENTRIES (ENTRIES),
        .COMP_W  (COMP_W),
        .PIX_REG (PIX_REG)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmp_wr  (cmp_wr),
        .wr_idx  (cur_idx),
        .wr_val  (payload),
        .pix_idx (pix_idx),
        .pix_rgb (pix_rgb)
    );

endmodule

// File: rtl/dac_checker.sv
module dac_checker #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [DATA_W/8-1:0]   be,
    input  logic [DATA_W-1:0]     rdata,
    input  logic [IDX_W-1:0]      cur_idx,
    input  dac_pkg::dac_phase_e   phase,
    input  logic [2:0]            cmp_wr
);
    import dac_pkg::*;

    logic full_be;
    logic bad_offset;
    assign full_be    = &be;
    assign bad_offset = (addr[1:0] != 2'b00) || (addr[ADDR_W-1:2] > 1);

    assert_one_comp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmp_wr));

    assert_red_to_green_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_wr[0] && !(wr_en && full_be && addr == '0)) |=> (phase == PH_GREEN));

    assert_green_to_blue_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_wr[1] |=> (phase == PH_BLUE));

    assert_idx_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full_be && addr == '0)
        |=> (cur_idx == $past(wdata[DATA_W-1 -: IDX_W]) && phase == PH_RED));

    assert_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_wr[2] |=> (cur_idx == IDX_W'($past(cur_idx) + 1'b1) && phase == PH_RED));

    assert_partial_be_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !full_be) |=> ($stable(cur_idx) && $stable(phase)));

    assert_bad_offset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bad_offset) |=> ($stable(cur_idx) && $stable(phase)));

    assert_read_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en) |=> ($stable(cur_idx) && $stable(phase)));

    assert_no_comp_without_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || !full_be) |-> (cmp_wr == 3'b000));

    assert_rdata_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (rdata == '0));

endmodule

bind palette_dac dac_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
) u_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .be      (be),
    .rdata   (rdata),
    .cur_idx (cur_idx),
    .phase   (phase),
    .cmp_wr  (cmp_wr)
);

// File: tb/tb_palette_dac.sv
`timescale 1ns/1ps
module tb_palette_dac;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [3:0]  be = '0;
    logic [31:0] rdata;
    logic [7:0]  pix_idx = '0;
    logic [23:0] pix_rgb;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    // Reference model
    logic [7:0] m_comp [3][256];
    logic [7:0] m_idx;
    int         m_phase;

    always #2 clk = ~clk;

    palette_dac dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wdata   (wdata),
        .be      (be),
        .rdata   (rdata),
        .pix_idx (pix_idx),
        .pix_rgb (pix_rgb)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic logic [23:0] model_rgb(input logic [7:0] e);
        return {m_comp[0][e], m_comp[1][e], m_comp[2][e]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_entry(input string req, input logic [7:0] e);
        pix_idx = e;
        #0.5;
        check(req, {8'h0, pix_rgb}, {8'h0, model_rgb(e)});
    endtask

    // Model updates: only legal full-word aligned writes act.
    task automatic model_write(input logic [3:0] a, input logic [31:0] d, input logic [3:0] b);
        if (b == 4'hF && a == 4'h0) begin
            m_idx   = d[31:24];
            m_phase = 0;
        end else if (b == 4'hF && a == 4'h4) begin
            m_comp[m_phase][m_idx] = d[31:24];
            if (m_phase == 2) begin
                m_phase = 0;
                m_idx   = m_idx + 8'd1;
            end else begin
                m_phase = m_phase + 1;
            end
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d, input logic [3:0] b);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d; be = b;
        @(negedge clk);
        wr_en = 1'b0; be = 4'h0;
        model_write(a, d, b);
    endtask

    task automatic bus_read(input logic [3:0] a);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #0.5;
        check("R7 rdata", rdata, 32'h0);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        for (int c = 0; c < 3; c++)
            for (int e = 0; e < 256; e++)
                m_comp[c][e] = (e == 255) ? 8'hFF : 8'h00;
        m_idx = 0;
        m_phase = 0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset contents
        for (int e = 0; e < 256; e++) check_entry("R1 reset entry", 8'(e));
        // R1/R3: first data write after reset lands in red of entry 0
        bus_write(4'h4, 32'h5A00_0000, 4'hF);
        check_entry("R1 first write is red", 8'h00);

        // R10: field packing with distinct components
        bus_write(4'h0, 32'h1000_0000, 4'hF);
        bus_write(4'h4, 32'hA100_0000, 4'hF);
        bus_write(4'h4, 32'hB200_0000, 4'hF);
        bus_write(4'h4, 32'hC300_0000, 4'hF);
        pix_idx = 8'h10; #0.5;
        check("R10 packing", {8'h0, pix_rgb}, 32'h00A1B2C3);

        // R9: low bits ignored on index and data
        bus_write(4'h0, 32'h07FF_FFFF, 4'hF);
        bus_write(4'h4, 32'h44AB_CDEF, 4'hF);
        check_entry("R9 low bits ignored", 8'h07);

        // R2: reload mid-triplet restarts at red
        bus_write(4'h0, 32'h0500_0000, 4'hF);
        bus_write(4'h4, 32'h1100_0000, 4'hF);
        bus_write(4'h0, 32'h0900_0000, 4'hF);
        bus_write(4'h4, 32'h2200_0000, 4'hF);
        check_entry("R2 reload red of 9", 8'h09);
        check_entry("R2 partial entry 5", 8'h05);

        // R4: wrap from 255 to 0
        bus_write(4'h0, 32'hFF00_0000, 4'hF);
        bus_write(4'h4, 32'h0100_0000, 4'hF);
        bus_write(4'h4, 32'h0200_0000, 4'hF);
        bus_write(4'h4, 32'h0300_0000, 4'hF);
        check_entry("R4 entry 255", 8'hFF);
        bus_write(4'h4, 32'h7700_0000, 4'hF);
        check_entry("R4 wrap to 0", 8'h00);

        // R8: old value before the edge, new value in the following cycle
        bus_write(4'h0, 32'h3000_0000, 4'hF);
        pix_idx = 8'h30;
        @(negedge clk);
        wr_en = 1'b1; addr = 4'h4; wdata = 32'hE700_0000; be = 4'hF;
        @(posedge clk);
        #(-0.0);
        check("R8 before edge", {8'h0, pix_rgb}, {8'h0, model_rgb(8'h30)});
        model_write(4'h4, 32'hE700_0000, 4'hF);
        #1;
        check("R8 after edge", {8'h0, pix_rgb}, {8'h0, model_rgb(8'h30)});
        @(negedge clk);
        wr_en = 1'b0; be = 4'h0;

        // R5 / R6 / R7 directed: next data write must land on green of 0x30
        bus_write(4'h4, 32'h9900_0000, 4'h7);
        bus_write(4'h8, 32'h9900_0000, 4'hF);
        bus_write(4'h5, 32'h9900_0000, 4'hF);
        bus_read(4'h4);
        check_entry("R5 R6 R7 table unchanged", 8'h30);
        bus_write(4'h4, 32'h6600_0000, 4'hF);
        check_entry("R5 R6 R7 phase unchanged", 8'h30);

        // Constrained random mix
        void'($urandom(32'd2024));
        for (int n = 0; n < 600; n++) begin
            int op;
            logic [31:0] d;
            op = int'($urandom % 10);
            d  = $urandom;
            case (op)
                0, 1: begin
                    bus_write(4'h0, d, 4'hF);
                    check_entry("R2 random index", m_idx);
                end
                2, 3, 4, 5, 9: begin
                    bus_write(4'h4, d, 4'hF);
                    check_entry("R3 random data", m_idx - ((m_phase == 0) ? 8'd1 : 8'd0));
                end
                6: begin
                    logic [3:0] b;
                    b = 4'($urandom % 15);
                    bus_write((d[0] ? 4'h4 : 4'h0), d, b);
                    check_entry("R5 random partial", m_idx);
                end
                7: begin
                    logic [3:0] a;
                    a = d[1] ? (d[0] ? 4'hC : 4'h8) : (d[0] ? 4'h1 : 4'h6);
                    bus_write(a, d, 4'hF);
                    check_entry("R6 random offset", m_idx);
                end
                default: begin
                    bus_read(4'($urandom % 16));
                end
            endcase
            if ((n % 8) == 0) check_entry("R3 random sweep", 8'($urandom));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule